// File: doc/BRIEF.md
# Three-Phase Complementary PWM Controller

This block drives a three-phase half-bridge power stage from one shared time base. A single counter runs either as an up-counter that wraps (edge-aligned) or as an up/down counter (center-aligned). Each of the three phases compares the count with its own on-time value to give a high-side demand. A dead-time stage then turns that demand into a high-side and a low-side drive that never conduct together. Polarity is applied per output at the pin.

Software writes the period, the three on-times, the dead time, an ADC trigger point and a control word through a simple write port. Period, on-time and trigger values are held in shadow registers and move into the working set only at a cycle boundary, so a PWM cycle never mixes old and new values. Three asynchronous emergency inputs are synchronized and latched into a fault flag. While the flag or a synchronized input is set, every output is held at its inactive level, and the output enables can also be dropped to give high impedance.

Top module: `tri_pwm_ctrl`

## Requirements
- R1: While rst_ni is low, pwm_o, pwm_oe_o, adc_trig_o and fault_o are all zero.
- R2: In edge-aligned mode (control bit 1 = 0) the count runs 0 to PERIOD and wraps, so the cycle is PERIOD+1 clocks long. With zero dead time, the high side of phase p is active for COMPARE_p clocks of each cycle, while count < COMPARE_p.
- R3: In center-aligned mode (control bit 1 = 1) the count rises from 0 to PERIOD and falls back to 1, so the cycle is 2*PERIOD clocks long. With zero dead time, the high side is active for 2*COMPARE_p-1 clocks of each cycle (0 < COMPARE_p <= PERIOD).
- R4: Register writes are decoded by address: 0 PERIOD, 1 to 3 COMPARE of phases 0 to 2, 4 dead time, 5 trigger point, 6 control. PERIOD, COMPARE and trigger writes take effect only when the count returns to 0 at a cycle boundary, or at once while stopped.
- R5: After one output of a pair goes inactive, its complement stays inactive for DEADTIME clocks. With dead time D, the high side is active COMPARE-D clocks and the low side PERIOD+1-COMPARE-D clocks per edge-aligned cycle.
- R6: The two outputs of a pair are never active in the same clock.
- R7: Output index 2p is the high side of phase p and 2p+1 is its low side. Control bits 4+i set the polarity of output i (1 = active-low), and the pin level is the active level XOR that bit.
- R8: While the fault flag or any synchronized emergency input is set, every pin is at its inactive level. Its enable is low if control bit 2 is 1 and high otherwise. Emergency inputs reach the pins three clock edges after they rise.
- R9: Any emergency input sets fault_o. A control write with bit 15 set clears it only if no synchronized emergency input is high at that moment.
- R10: adc_trig_o pulses for one clock, one clock after the count equals the trigger point. In center-aligned mode it pulses only on the slope selected by control bit 3 (0 rising, 1 falling).
- R11: With control bit 0 (run) low, the count is held at 0, every pin is at its inactive level with its enable high, and no trigger pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Register write data |
| flt_i | input | 3 | Asynchronous emergency inputs, active high |
| pwm_o | output | 6 | Pin levels, even index high side, odd index low side |
| pwm_oe_o | output | 6 | Per-pin output enable |
| adc_trig_o | output | 1 | One-clock ADC trigger pulse |
| fault_o | output | 1 | Latched fault flag |

## Verification
The bench goes after shadow-register timing. A period written mid-cycle must not alter the cycle already running, and a design that loads it at once would shorten or stretch that cycle, which shows up as a wrong spacing between trigger pulses. It measures on-times with and without dead time in both counting modes. A dead-time stage that lets the complement turn on early would show an extra active clock and an overlap of the pair. It clears the fault while an emergency input is still high and again after the input drops. A design that clears unconditionally, or that leaves the enables driven when high impedance is selected, diverges from the clock-by-clock reference.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  localparam int CB_RUN    = 0;
  localparam int CB_CENTER = 1;
  localparam int CB_HIZ    = 2;
  localparam int CB_TRIGDN = 3;
  localparam int CB_POL    = 4;
  localparam int CB_CLR    = 15;

  typedef enum logic [1:0] {
    SIDE_HI = 2'd0,
    SIDE_LO = 2'd1
  } side_e;
endpackage

// File: rtl/tpwm_timebase.sv
module tpwm_timebase #(
  parameter int CNT_W = 12,
  parameter int N_PH  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       run_i,
  input  logic                       center_i,
  input  logic                       trig_dn_i,
  input  logic [CNT_W-1:0]           per_sh_i,
  input  logic [N_PH-1:0][CNT_W-1:0] cmp_sh_i,
  input  logic [CNT_W-1:0]           trig_sh_i,
  output logic [N_PH-1:0]            raw_o,
  output logic                       trig_o
);
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic                       down_q, down_d;
  logic [CNT_W-1:0]           per_q, trig_q;
  logic [N_PH-1:0][CNT_W-1:0] cmp_q;
  logic                       load;
  logic                       trig_hit, trig_r;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    load   = 1'b0;
    if (!run_i) begin
      cnt_d  = '0;
      down_d = 1'b0;
      load   = 1'b1;
    end else if (!center_i) begin
      down_d = 1'b0;
      if (cnt_q >= per_q) begin
        cnt_d = '0;
        load  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (!down_q) begin
      if (cnt_q >= per_q) begin
        if (cnt_q == '0) begin
          load = 1'b1;
        end else begin
          down_d = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d  = '0;
        down_d = 1'b0;
        load   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      per_q  <= '0;
      trig_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      if (load) begin
        per_q  <= per_sh_i;
        trig_q <= trig_sh_i;
      end
    end
  end

  for (genvar p = 0; p < N_PH; p++) begin : g_phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cmp_q[p] <= '0;
      else if (load) cmp_q[p] <= cmp_sh_i[p];
    end
    assign raw_o[p] = run_i && (cnt_q < cmp_q[p]);
  end

  assign trig_hit = run_i && (cnt_q == trig_q) && (!center_i || (down_q == trig_dn_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_r <= 1'b0;
    else         trig_r <= trig_hit;
  end
  assign trig_o = trig_r;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> (cnt_q <= per_q)); // R2
  AST_LOAD_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_q) |-> (cnt_q == '0)); // R4
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> (cnt_q == '0)); // R11
endmodule

// File: rtl/tpwm_deadband.sv
module tpwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            raw_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            act_h_o,
  output logic            act_l_o
);
  logic            cur_q;
  logic [DT_W-1:0] dc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= 1'b0;
      dc_q  <= '0;
    end else if (raw_i != cur_q) begin
      cur_q <= raw_i;
      dc_q  <= dt_i;
    end else if (dc_q != '0) begin
      dc_q <= dc_q - 1'b1;
    end
  end

  assign act_h_o = cur_q && (dc_q == '0);
  assign act_l_o = !cur_q && (dc_q == '0);

  AST_DT_GAP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dt_i) != '0 && $past(act_h_o) && !act_h_o) |-> !act_l_o); // R5
  AST_DT_GAP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dt_i) != '0 && $past(act_l_o) && !act_l_o) |-> !act_h_o); // R5
endmodule

// File: rtl/tpwm_fault.sv
module tpwm_fault #(
  parameter int N_FLT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_FLT-1:0] flt_i,
  input  logic             clr_i,
  output logic             any_o,
  output logic             flag_o
);
  logic [N_FLT-1:0] s1_q, s2_q;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      s1_q   <= flt_i;
      s2_q   <= s1_q;
      flag_q <= any_o || (flag_q && !clr_i);
    end
  end

  assign any_o  = |s2_q;
  assign flag_o = flag_q;

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && any_o) |=> flag_q); // R9
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |=> flag_q); // R9
endmodule

// File: rtl/tri_pwm_ctrl.sv
module tri_pwm_ctrl #(
  parameter int CNT_W  = 12,
  parameter int DT_W   = 8,
  parameter int N_PH   = 3,
  parameter int N_FLT  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N_FLT-1:0]  flt_i,
  output logic [2*N_PH-1:0] pwm_o,
  output logic [2*N_PH-1:0] pwm_oe_o,
  output logic              adc_trig_o,
  output logic              fault_o
);
  import tpwm_pkg::*;

  localparam int N_OUT  = 2 * N_PH;
  localparam int A_PER  = 0;
  localparam int A_DT   = N_PH + 1;
  localparam int A_TRIG = N_PH + 2;
  localparam int A_CTRL = N_PH + 3;

  logic [CNT_W-1:0]           per_sh, trig_sh;
  logic [N_PH-1:0][CNT_W-1:0] cmp_sh;
  logic [DT_W-1:0]            dt_q;
  logic                       run_q, center_q, hiz_q, trig_dn_q;
  logic [N_OUT-1:0]           pol_q;
  logic                       ctrl_wr, clr;
  logic [N_PH-1:0]            raw;
  logic [N_OUT-1:0]           act;
  logic                       any_flt, flag, safe;
  logic [N_OUT-1:0]           pwm_q, oe_q;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
  assign clr     = ctrl_wr && wr_data_i[CB_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_sh    <= '0;
      trig_sh   <= '0;
      dt_q      <= '0;
      run_q     <= 1'b0;
      center_q  <= 1'b0;
      hiz_q     <= 1'b0;
      trig_dn_q <= 1'b0;
      pol_q     <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(A_PER))  per_sh  <= wr_data_i[CNT_W-1:0];
      if (wr_addr_i == ADDR_W'(A_TRIG)) trig_sh <= wr_data_i[CNT_W-1:0];
      if (wr_addr_i == ADDR_W'(A_DT))   dt_q    <= wr_data_i[DT_W-1:0];
      if (ctrl_wr) begin
        run_q     <= wr_data_i[CB_RUN];
        center_q  <= wr_data_i[CB_CENTER];
        hiz_q     <= wr_data_i[CB_HIZ];
        trig_dn_q <= wr_data_i[CB_TRIGDN];
        pol_q     <= wr_data_i[CB_POL +: N_OUT];
      end
    end
  end

  for (genvar p = 0; p < N_PH; p++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmp_sh[p] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(p + 1)) cmp_sh[p] <= wr_data_i[CNT_W-1:0];
    end
  end

  tpwm_timebase #(.CNT_W(CNT_W), .N_PH(N_PH)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .center_i  (center_q),
    .trig_dn_i (trig_dn_q),
    .per_sh_i  (per_sh),
    .cmp_sh_i  (cmp_sh),
    .trig_sh_i (trig_sh),
    .raw_o     (raw),
    .trig_o    (adc_trig_o)
  );

  for (genvar p = 0; p < N_PH; p++) begin : g_pair
    tpwm_deadband #(.DT_W(DT_W)) u_db (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (raw[p]),
      .dt_i    (dt_q),
      .act_h_o (act[2*p + int'(SIDE_HI)]),
      .act_l_o (act[2*p + int'(SIDE_LO)])
    );
  end

  tpwm_fault #(.N_FLT(N_FLT)) u_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flt_i  (flt_i),
    .clr_i  (clr),
    .any_o  (any_flt),
    .flag_o (flag)
  );

  assign safe = flag || any_flt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= '0;
      oe_q  <= '0;
    end else begin
      pwm_q <= (safe || !run_q) ? pol_q : (act ^ pol_q);
      oe_q  <= (safe && hiz_q) ? '0 : '1;
    end
  end

  assign pwm_o    = pwm_q;
  assign pwm_oe_o = oe_q;
  assign fault_o  = flag;

  for (genvar p = 0; p < N_PH; p++) begin : g_chk
    AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !((pwm_q[2*p] ^ $past(pol_q[2*p])) && (pwm_q[2*p+1] ^ $past(pol_q[2*p+1])))); // R6
  end
  AST_SAFE_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(safe) |-> (pwm_q == $past(pol_q))); // R8
  AST_SAFE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(safe && hiz_q) |-> (oe_q == '0)); // R8
endmodule

// File: tb/sim_tri_pwm_ctrl.sv
module sim_tri_pwm_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0] flt = '0;
  logic [5:0] pwm, oe;
  logic       trg, flt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tri_pwm_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .flt_i(flt), .pwm_o(pwm), .pwm_oe_o(oe),
    .adc_trig_o(trg), .fault_o(flt_o)
  );

  // reference model state
  int s_per, s_trig, s_dt, s_cmp[3];
  bit c_run, c_center, c_hiz, c_tdn;
  bit [5:0] c_pol, m_opol;
  int m_cnt, m_per, m_trig, m_cmp[3], m_dc[3];
  bit m_down, m_cur[3];
  bit [2:0] m_s1, m_s2;
  bit m_flag, m_trg;
  bit [5:0] m_pwm, m_oe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_per = 0; s_trig = 0; s_dt = 0; c_run = 0; c_center = 0; c_hiz = 0; c_tdn = 0;
      c_pol = 0; m_opol = 0; m_cnt = 0; m_per = 0; m_trig = 0; m_down = 0;
      for (int p = 0; p < 3; p++) begin s_cmp[p] = 0; m_cmp[p] = 0; m_dc[p] = 0; m_cur[p] = 0; end
      m_s1 = 0; m_s2 = 0; m_flag = 0; m_trg = 0; m_pwm = 0; m_oe = 0;
    end else begin
      bit any, safe, load, ndown, clr;
      bit [5:0] a;
      bit rw[3];
      int ncnt;
      any = (m_s2 != 0);
      safe = m_flag || any;
      for (int p = 0; p < 3; p++) begin
        a[2*p]   = m_cur[p] && m_dc[p] == 0;
        a[2*p+1] = !m_cur[p] && m_dc[p] == 0;
        rw[p]    = c_run && (m_cnt < m_cmp[p]);
      end
      m_pwm = (safe || !c_run) ? c_pol : (a ^ c_pol);
      m_oe  = (safe && c_hiz) ? 6'h00 : 6'h3f;
      m_opol = c_pol;
      m_trg = c_run && (m_cnt == m_trig) && (!c_center || (m_down == c_tdn));
      for (int p = 0; p < 3; p++) begin
        if (rw[p] != m_cur[p]) begin m_cur[p] = rw[p]; m_dc[p] = s_dt; end
        else if (m_dc[p] != 0) m_dc[p] = m_dc[p] - 1;
      end
      clr = wr_en && wr_addr == 6 && wr_data[15];
      m_flag = any || (m_flag && !clr);
      m_s2 = m_s1; m_s1 = flt;
      load = 0; ncnt = m_cnt; ndown = m_down;
      if (!c_run) begin ncnt = 0; ndown = 0; load = 1; end
      else if (!c_center) begin
        ndown = 0;
        if (m_cnt >= m_per) begin ncnt = 0; load = 1; end else ncnt = m_cnt + 1;
      end else if (!m_down) begin
        if (m_cnt >= m_per) begin
          if (m_cnt == 0) load = 1; else begin ndown = 1; ncnt = m_cnt - 1; end
        end else ncnt = m_cnt + 1;
      end else begin
        if (m_cnt <= 1) begin ncnt = 0; ndown = 0; load = 1; end else ncnt = m_cnt - 1;
      end
      m_cnt = ncnt; m_down = ndown;
      if (load) begin
        m_per = s_per; m_trig = s_trig;
        for (int p = 0; p < 3; p++) m_cmp[p] = s_cmp[p];
      end
      if (wr_en) begin
        case (wr_addr)
          0: s_per = wr_data[11:0];
          1, 2, 3: s_cmp[wr_addr-1] = wr_data[11:0];
          4: s_dt = wr_data[7:0];
          5: s_trig = wr_data[11:0];
          6: begin
            c_run = wr_data[0]; c_center = wr_data[1]; c_hiz = wr_data[2];
            c_tdn = wr_data[3]; c_pol = wr_data[9:4];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pwm == m_pwm, "R7 pin level", pwm, m_pwm);
      chk(oe == m_oe, "R8 enable", oe, m_oe);
      chk(trg == m_trg, "R10 trigger", trg, m_trg);
      chk(flt_o == m_flag, "R9 fault flag", flt_o, m_flag);
      for (int p = 0; p < 3; p++)
        chk(!((pwm[2*p] ^ m_opol[2*p]) && (pwm[2*p+1] ^ m_opol[2*p+1])), "R6 overlap", pwm, m_opol);
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_act(input int idx, input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm[idx] ^ m_opol[idx]) c++;
    end
  endtask

  initial begin
    int c, t0, t1, t2;
    #1;
    chk(pwm == 0 && oe == 0 && trg == 0 && flt_o == 0, "R1 reset", {pwm, oe}, 0);
    idle(3);
    chk(pwm == 0 && oe == 0 && trg == 0 && flt_o == 0, "R1 reset hold", {pwm, oe}, 0);
    rst_n = 1;

    // R2 edge-aligned, no dead time
    wr(0, 9); wr(1, 4); wr(2, 2); wr(3, 7); wr(4, 0); wr(5, 0); wr(6, 1);
    idle(25);
    count_act(0, 10, c); chk(c == 4, "R2 high-side on-time", c, 4);
    count_act(1, 10, c); chk(c == 6, "R2 low-side on-time", c, 6);
    count_act(4, 10, c); chk(c == 7, "R2 phase 2 on-time", c, 7);

    // R5 dead time
    wr(6, 0); wr(0, 19); wr(1, 8); wr(4, 3); wr(6, 1);
    idle(45);
    count_act(0, 20, c); chk(c == 5, "R5 high side with dead time", c, 5);
    count_act(1, 20, c); chk(c == 9, "R5 low side with dead time", c, 9);

    // R3 center-aligned, R10 falling-slope trigger
    wr(6, 0); wr(4, 0); wr(0, 8); wr(1, 3); wr(5, 2); wr(6, 'b1011);
    idle(40);
    count_act(0, 16, c); chk(c == 5, "R3 center high-side on-time", c, 5);
    c = 0;
    repeat (16) begin @(negedge clk); if (trg) c++; end
    chk(c == 1, "R10 one pulse per center cycle", c, 1);

    // R4 period buffered until wrap
    wr(6, 0); wr(0, 9); wr(5, 0); wr(6, 1);
    idle(30);
    t0 = 0;
    while (!trg) begin @(negedge clk); t0++; end
    idle(3);
    wr(0, 19);
    t1 = 0;
    do begin @(negedge clk); t1++; end while (!trg);
    chk(t1 <= 10, "R4 old period still running", t1, 10);
    t2 = 0;
    do begin @(negedge clk); t2++; end while (!trg);
    chk(t2 == 20, "R4 new period after boundary", t2, 20);

    // R11 stopped, R7 active-low polarity
    wr(6, 'h3f0);
    idle(3);
    chk(pwm == 6'h3f, "R11 stopped inactive pins", pwm, 6'h3f);
    chk(oe == 6'h3f, "R11 stopped enables", oe, 6'h3f);
    c = 0;
    repeat (20) begin @(negedge clk); if (trg) c++; end
    chk(c == 0, "R11 no trigger when stopped", c, 0);
    wr(6, 'h3f1);
    idle(30);

    // R8 / R9 fault with high impedance
    wr(6, 'b101);
    idle(20);
    flt = 3'b010;
    idle(5);
    chk(oe == 0, "R8 hi-z enables", oe, 0);
    chk(flt_o == 1, "R9 flag set", flt_o, 1);
    wr(6, 'h8005);
    idle(3);
    chk(flt_o == 1, "R9 clear ignored while input high", flt_o, 1);
    flt = 0;
    idle(6);
    chk(flt_o == 1 && oe == 0, "R9 flag latched after input drops", flt_o, 1);
    wr(6, 'h8005);
    idle(3);
    chk(flt_o == 0 && oe == 6'h3f, "R9 clear accepted", {flt_o, oe}, 'h3f);

    // R8 inactive-state fault
    wr(6, 'b1);
    idle(10);
    flt = 3'b100;
    idle(4);
    chk(pwm == 0 && oe == 6'h3f, "R8 inactive-state fault", {pwm, oe}, 'h3f);
    flt = 0;
    idle(4);
    wr(6, 'h8001);
    idle(20);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule